// File: doc/BRIEF.md
# Serial NOR Flash Host Sequencer

This block lets on-chip logic read, program and erase an external serial NOR flash without handling the bus protocol. A client presents one request at a time: an operation code, a 24-bit flash address and, for transfers, a byte count. The block generates the chip select, serial clock and data-out line in SPI mode 0, and sends the command byte, address bytes and any dummy byte, all most significant bit first. Read bytes are returned one at a time on a valid strobe. Program bytes are pulled from the client through a valid/ready handshake.

For every operation that modifies the array, the block first runs a separate write-enable transaction. After the modifying command it runs a status poll: one select period in which status bytes are read back to back until the busy flag is clear. It reports completion only after that. A program request that is empty or would run past the end of its 256-byte page is refused with an error, and the bus is not touched.

Top module: `spi_flash_host`

## Requirements
- R1: Out of reset, `flash_cs_n` is 1, `flash_sck` is 0, `req_ready` is 1 and `done` is 0.
- R2: The serial clock idles low. `flash_mosi` never changes on a cycle where `flash_sck` rises, and `flash_sck` is never high while `flash_cs_n` is high. Every byte goes out bit 7 first.
- R3: `req_op`=0 (plain read) sends one transaction 03h, A[23:16], A[15:8], A[7:0], followed by `req_len` filler bytes. Each byte shifted in during the filler is presented once on `rd_data` with `rd_valid`, in address order.
- R4: `req_op`=1 (fast read) works like R3 with opcode 0Bh, plus one extra byte between the address and the first returned byte. That byte is not returned.
- R5: `req_op`=2 (page program) sends a one-byte transaction 06h, then a transaction of 02h, three address bytes and `req_len` data bytes. The data bytes are taken from `wr_data` in order, one per cycle where `wr_valid` and `wr_ready` are both high.
- R6: `req_op`=3, 4 and 5 (erase) send 06h in its own transaction, then 20h, 52h or D8h followed by the three address bytes. `req_op`=6 sends 06h, then C7h alone.
- R7: After each R5 or R6 command, one further transaction starts with 05h and reads status bytes continuously until a byte with bit 0 equal to 0 arrives. Then `flash_cs_n` rises and `done` pulses.
- R8: `req_op`=7 sends 05h and returns exactly one status byte on `rd_data`.
- R9: A program request with `req_len`=0, or with A[7:0]+`req_len` greater than 256, and a read request with `req_len`=0, produce `done` with `err`=1 and no select assertion.
- R10: Between two transactions of one request, `flash_cs_n` stays high for at least 2*DIV_HALF clock cycles.
- R11: `req_ready` is low from the cycle after acceptance until `done`. `done` is a single-cycle pulse, and `req_ready` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_op | input | 3 | Operation code 0..7 (see R3-style list above per tag) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Byte count for read and program, 1..256 |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Program byte consumed this cycle |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Returned byte strobe |
| rd_data | output | 8 | Returned read or status byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with done |
| flash_sck | output | 1 | Serial clock to flash |
| flash_cs_n | output | 1 | Active-low flash select |
| flash_mosi | output | 1 | Serial data to flash |
| flash_miso | input | 1 | Serial data from flash |

## Verification
A behavioural flash model on the bench decodes each select period into bytes. It answers reads from an address-derived pattern and answers status reads with a programmable number of busy bytes. Plain and fast reads at random addresses show whether the dummy byte is inserted and whether returned data keeps address order, since a one-byte misalignment changes every value. Programs whose lengths end exactly on the page edge and whose lengths end one byte past it separate correct boundary arithmetic from off-by-one errors, and a full 256-byte page checks the widest count. Erases with zero to several busy bytes show whether the poll exits on bit 0 and stays in one select period.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_FREAD     = 3'd1,
    OP_PROG      = 3'd2,
    OP_ERASE_4K  = 3'd3,
    OP_ERASE_32K = 3'd4,
    OP_ERASE_64K = 3'd5,
    OP_ERASE_ALL = 3'd6,
    OP_STATUS    = 3'd7
  } flash_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_GAP,
    S_CMD,
    S_ADDR,
    S_DUMMY,
    S_DATA,
    S_POLL_CMD,
    S_POLL_RD,
    S_DONE
  } seq_state_e;

  localparam logic [7:0] CMD_WRITE_EN = 8'h06;
  localparam logic [7:0] CMD_STATUS   = 8'h05;

  // Command byte sent on the bus for each request code
  function automatic logic [7:0] op_command(input flash_op_e op);
    case (op)
      OP_READ:      return 8'h03;
      OP_FREAD:     return 8'h0B;
      OP_PROG:      return 8'h02;
      OP_ERASE_4K:  return 8'h20;
      OP_ERASE_32K: return 8'h52;
      OP_ERASE_64K: return 8'hD8;
      OP_ERASE_ALL: return 8'hC7;
      default:      return CMD_STATUS;
    endcase
  endfunction

  function automatic logic op_modifies(input flash_op_e op);
    return (op == OP_PROG) || (op == OP_ERASE_4K) || (op == OP_ERASE_32K) ||
           (op == OP_ERASE_64K) || (op == OP_ERASE_ALL);
  endfunction

  function automatic logic op_returns_data(input flash_op_e op);
    return (op == OP_READ) || (op == OP_FREAD) || (op == OP_STATUS);
  endfunction

  function automatic logic op_sends_addr(input flash_op_e op);
    return (op != OP_ERASE_ALL) && (op != OP_STATUS);
  endfunction

endpackage

// File: rtl/spi_flash_shifter.sv
module spi_flash_shifter #(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  localparam int CNT_W = $clog2(DIV_HALF) + 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(DIV_HALF - 1);

  logic             active_q;
  logic             sck_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;
  logic             done_q;

  // Named internal events for the checks below
  logic half_tick;
  logic edge_rise;
  logic edge_fall;
  assign half_tick = active_q && (cnt_q == '0);
  assign edge_rise = half_tick && !sck_q;
  assign edge_fall = half_tick && sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          cnt_q    <= HALF_LAST;
          bit_q    <= '0;
        end
      end else if (!half_tick) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= HALF_LAST;
        if (edge_rise) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign busy_o = active_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R2: data out is settled before the flash samples it
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> $stable(mosi_o));

  // R2: a byte is never restarted while one is still shifting
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_q);

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_flash_pkg::*;
#(
  parameter  int ADDR_BYTES = 3,
  parameter  int PAGE_BYTES = 256,
  parameter  int GAP_CYC    = 8,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic              cs_n,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);

  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int GCNT_W = $clog2(GAP_CYC + 1);
  localparam int OFF_W  = LEN_W - 1;
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(ADDR_BYTES - 1);
  localparam logic [GCNT_W-1:0] GAP_LAST = GCNT_W'(GAP_CYC - 1);

  // Page-fit arithmetic: offset within page plus count must not pass the page end
  function automatic logic fits_page(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] n);
    logic [LEN_W:0] span;
    span = (LEN_W+1)'(a[OFF_W-1:0]) + (LEN_W+1)'(n);
    return (n != '0) && (span <= (LEN_W+1)'(PAGE_BYTES));
  endfunction

  function automatic logic request_ok(input flash_op_e op, input logic [ADDR_W-1:0] a,
                                      input logic [LEN_W-1:0] n);
    case (op)
      OP_PROG:           return fits_page(a, n);
      OP_READ, OP_FREAD: return n != '0;
      default:           return 1'b1;
    endcase
  endfunction

  seq_state_e        state_q, after_gap_q;
  flash_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GCNT_W-1:0] gcnt_q;
  logic              pend_q;
  logic              err_q;
  logic              cs_q;
  logic              rdv_q;
  logic [7:0]        rdd_q;
  logic              wren_sent_q;

  flash_op_e req_op_e;
  assign req_op_e = flash_op_e'(req_op);

  // Named internal events
  logic byte_state;
  logic prog_data;
  logic data_gate;
  logic accept;
  logic poll_busy;
  assign byte_state = (state_q == S_WREN) || (state_q == S_CMD) || (state_q == S_ADDR) ||
                      (state_q == S_DUMMY) || (state_q == S_DATA) ||
                      (state_q == S_POLL_CMD) || (state_q == S_POLL_RD);
  assign prog_data  = (state_q == S_DATA) && (op_q == OP_PROG);
  assign data_gate  = !prog_data || wr_valid;
  assign accept     = (state_q == S_IDLE) && req_valid;
  assign poll_busy  = (state_q == S_POLL_RD) && eng_done && eng_rx[0];

  always_comb begin
    case (state_q)
      S_WREN:     eng_tx = CMD_WRITE_EN;
      S_CMD:      eng_tx = op_command(op_q);
      S_ADDR:     eng_tx = addr_q[8*(ADDR_BYTES-1-int'(idx_q)) +: 8];
      S_DATA:     eng_tx = prog_data ? wr_data : 8'h00;
      S_POLL_CMD: eng_tx = CMD_STATUS;
      default:    eng_tx = 8'h00;
    endcase
  end

  assign eng_start = byte_state && !pend_q && data_gate;
  assign wr_ready  = eng_start && prog_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      after_gap_q <= S_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      left_q      <= '0;
      idx_q       <= '0;
      gcnt_q      <= '0;
      pend_q      <= 1'b0;
      err_q       <= 1'b0;
      cs_q        <= 1'b1;
      rdv_q       <= 1'b0;
      rdd_q       <= '0;
      wren_sent_q <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      if (eng_start) pend_q <= 1'b1;
      if (eng_done)  pend_q <= 1'b0;

      case (state_q)
        S_IDLE: begin
          if (accept) begin
            op_q        <= req_op_e;
            addr_q      <= req_addr;
            left_q      <= (req_op_e == OP_STATUS) ? LEN_W'(1) : req_len;
            idx_q       <= '0;
            err_q       <= 1'b0;
            wren_sent_q <= 1'b0;
            if (!request_ok(req_op_e, req_addr, req_len)) begin
              err_q   <= 1'b1;
              state_q <= S_DONE;
            end else begin
              cs_q    <= 1'b0;
              state_q <= op_modifies(req_op_e) ? S_WREN : S_CMD;
            end
          end
        end

        S_WREN: if (eng_done) begin
          wren_sent_q <= 1'b1;
          cs_q        <= 1'b1;
          gcnt_q      <= GAP_LAST;
          after_gap_q <= S_CMD;
          state_q     <= S_GAP;
        end

        S_GAP: begin
          if (gcnt_q == '0) begin
            state_q <= after_gap_q;
            if (after_gap_q != S_DONE) cs_q <= 1'b0;
          end else begin
            gcnt_q <= gcnt_q - 1'b1;
          end
        end

        S_CMD: if (eng_done) begin
          if (op_q == OP_STATUS) begin
            state_q <= S_DATA;
          end else if (!op_sends_addr(op_q)) begin
            cs_q        <= 1'b1;
            gcnt_q      <= GAP_LAST;
            after_gap_q <= S_POLL_CMD;
            state_q     <= S_GAP;
          end else begin
            idx_q   <= '0;
            state_q <= S_ADDR;
          end
        end

        S_ADDR: if (eng_done) begin
          if (idx_q == IDX_LAST) begin
            if (op_q == OP_FREAD) begin
              state_q <= S_DUMMY;
            end else if (op_modifies(op_q) && (op_q != OP_PROG)) begin
              cs_q        <= 1'b1;
              gcnt_q      <= GAP_LAST;
              after_gap_q <= S_POLL_CMD;
              state_q     <= S_GAP;
            end else begin
              state_q <= S_DATA;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end

        S_DUMMY: if (eng_done) state_q <= S_DATA;

        S_DATA: if (eng_done) begin
          if (op_returns_data(op_q)) begin
            rdv_q <= 1'b1;
            rdd_q <= eng_rx;
          end
          if (left_q == LEN_W'(1)) begin
            cs_q        <= 1'b1;
            gcnt_q      <= GAP_LAST;
            after_gap_q <= (op_q == OP_PROG) ? S_POLL_CMD : S_DONE;
            state_q     <= S_GAP;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end

        S_POLL_CMD: if (eng_done) state_q <= S_POLL_RD;

        S_POLL_RD: if (eng_done && !eng_rx[0]) begin
          cs_q        <= 1'b1;
          gcnt_q      <= GAP_LAST;
          after_gap_q <= S_DONE;
          state_q     <= S_GAP;
        end

        S_DONE: state_q <= S_IDLE;

        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign done      = (state_q == S_DONE);
  assign err       = done && err_q;
  assign cs_n      = cs_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  // R5/R6: the modifying command never starts before write-enable went out
  p_wren_before_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CMD && eng_start && op_modifies(op_q)) |-> wren_sent_q);

  // R10: bytes are shifted only inside a select period
  p_start_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !cs_n);

  // R3: returned-byte strobes appear only for requests that return data
  p_rd_only_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> op_returns_data(op_q));

  // R7: a busy status byte keeps polling inside the same select period
  p_poll_continues_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_busy |=> (state_q == S_POLL_RD) && !cs_n);

  // R9: a refused request never wrote the enable command
  p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !wren_sent_q));

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

endmodule

// File: rtl/spi_flash_host.sv
module spi_flash_host #(
  parameter  int DIV_HALF   = 4,
  parameter  int ADDR_BYTES = 3,
  parameter  int PAGE_BYTES = 256,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic              flash_sck,
  output logic              flash_cs_n,
  output logic              flash_mosi,
  input  logic              flash_miso
);

  localparam int GAP_CYC = 2 * DIV_HALF;

  logic       eng_start;
  logic [7:0] eng_tx;
  logic       eng_busy;
  logic       eng_done;
  logic [7:0] eng_rx;

  spi_flash_seq #(
    .ADDR_BYTES (ADDR_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .GAP_CYC    (GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .done      (done),
    .err       (err),
    .cs_n      (flash_cs_n),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx)
  );

  spi_flash_shifter #(
    .DIV_HALF (DIV_HALF)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .tx_i    (eng_tx),
    .miso_i  (flash_miso),
    .sck_o   (flash_sck),
    .mosi_o  (flash_mosi),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  // R2: the clock never runs while the flash is deselected
  p_sck_low_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);

  // R10: select cannot rise while a byte is still shifting
  p_cs_rise_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_cs_n) |-> !eng_busy);

endmodule

// File: tb/sim_spi_flash_host.sv
`timescale 1ns/1ps
module sim_spi_flash_host;

  localparam int DIVH   = 2;
  localparam int GAPMIN = 2 * DIVH;
  localparam int MAXB   = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [8:0]  req_len = '0;
  logic        wr_valid;
  logic        wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        done;
  logic        err;
  logic        flash_sck;
  logic        flash_cs_n;
  logic        flash_mosi;
  logic        flash_miso;

  always #2 clk = ~clk;

  spi_flash_host #(.DIV_HALF(DIVH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .flash_sck(flash_sck), .flash_cs_n(flash_cs_n), .flash_mosi(flash_mosi),
    .flash_miso(flash_miso)
  );

  int checks = 0;
  int errors = 0;
  logic hung = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] mem_at(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] cmd_of(input int op);
    case (op)
      0: return 8'h03;  1: return 8'h0B;  2: return 8'h02;  3: return 8'h20;
      4: return 8'h52;  5: return 8'hD8;  6: return 8'hC7;  default: return 8'h05;
    endcase
  endfunction

  // Stimulus configuration shared with the flash agent
  int         op_id = 0;
  int         busy_cfg = 0;
  logic [7:0] stat_val = 8'h02;
  logic [7:0] wr_buf [0:MAXB-1];
  int         wr_cnt = 0;

  // Flash agent state (written only by the agent block)
  logic [7:0] lg [0:3][0:MAXB-1];
  int         lgn [0:3];
  int         ntx, cur, nb, bitc, sidx, gapc, min_gap, viol, seen_id;
  logic [7:0] in_b, out_sh, cmd;
  logic [23:0] maddr;
  logic       prev_cs, prev_sck, prev_mosi;
  logic [7:0] rd_buf [0:MAXB-1];
  int         rd_n;
  int         wr_idx;
  logic       wr_took;
  logic       miso_q;

  assign flash_miso = miso_q;
  assign wr_valid = (wr_idx < wr_cnt);
  assign wr_data  = wr_buf[(wr_idx < MAXB) ? wr_idx : 0];

  function automatic logic [7:0] next_out(input logic [7:0] c, input int n,
                                          input logic [23:0] a, input int si);
    if (c == 8'h03 && n >= 4) return mem_at(a + 24'(n - 4));
    if (c == 8'h0B && n >= 5) return mem_at(a + 24'(n - 5));
    if (c == 8'h05 && n >= 1) return (si < busy_cfg) ? (stat_val | 8'h01) : (stat_val & 8'hFE);
    return 8'h00;
  endfunction

  initial begin
    ntx = 0; cur = 0; nb = 0; bitc = 0; sidx = 0; gapc = 0; min_gap = 999; viol = 0;
    seen_id = 0; in_b = 0; out_sh = 0; cmd = 0; maddr = 0; prev_cs = 1; prev_sck = 0;
    prev_mosi = 0; rd_n = 0; wr_idx = 0; wr_took = 0; miso_q = 0;
    for (int i = 0; i < 4; i++) lgn[i] = 0;
  end

  always @(negedge clk) begin
    if (seen_id != op_id) begin
      seen_id = op_id; ntx = 0; min_gap = 999; viol = 0; rd_n = 0; wr_idx = 0; wr_took = 0;
      for (int i = 0; i < 4; i++) lgn[i] = 0;
    end
    // program-data feeder
    if (wr_took) wr_idx = wr_idx + 1;
    wr_took = wr_ready && wr_valid;
    // returned bytes
    if (rd_valid && rd_n < MAXB) begin rd_buf[rd_n] = rd_data; rd_n = rd_n + 1; end
    // bus decode
    if (prev_cs && !flash_cs_n) begin
      if (ntx > 0 && gapc < min_gap) min_gap = gapc;
      cur = ntx; ntx = ntx + 1; nb = 0; bitc = 0; sidx = 0; out_sh = 0; gapc = 0;
    end
    if (flash_cs_n) begin
      gapc = gapc + 1;
      if (flash_sck) viol = viol + 1;
    end
    if (!flash_cs_n && !prev_sck && flash_sck) begin
      if (flash_mosi != prev_mosi) viol = viol + 1;
      in_b = {in_b[6:0], flash_mosi};
      bitc = bitc + 1;
      if (bitc == 8) begin
        bitc = 0;
        if (cur < 4 && nb < MAXB) begin lg[cur][nb] = in_b; lgn[cur] = nb + 1; end
        if (nb == 0) cmd = in_b;
        if (nb >= 1 && nb <= 3) maddr = {maddr[15:0], in_b};
        nb = nb + 1;
        out_sh = next_out(cmd, nb, maddr, sidx);
        if (cmd == 8'h05 && nb >= 1) sidx = sidx + 1;
      end
    end
    if (!flash_cs_n && prev_sck && !flash_sck) begin
      miso_q = out_sh[7];
      out_sh = {out_sh[6:0], 1'b0};
    end
    prev_cs = flash_cs_n; prev_sck = flash_sck; prev_mosi = flash_mosi;
  end

  logic got_err;

  task automatic run_op(input int op, input logic [23:0] addr, input int len,
                        input int busy, input logic [7:0] sv);
    int waited;
    if (hung) return;
    busy_cfg = busy; stat_val = sv; op_id = op_id + 1;
    req_op = 3'(op); req_addr = addr; req_len = 9'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 ready low after accept", int'(req_ready), 0);
    waited = 0;
    while (!done && waited < 40000) begin @(negedge clk); waited++; end
    if (!done) begin chk("watchdog", 0, 1); hung = 1'b1; return; end
    got_err = err;
    @(negedge clk);
    chk("R11 done pulse / ready back", int'({done, req_ready}), 1);
  endtask

  function automatic logic [23:0] log_addr(input int t);
    return {lg[t][1], lg[t][2], lg[t][3]};
  endfunction

  task automatic check_op(input int op, input logic [23:0] addr, input int len,
                          input int busy, input logic exp_err);
    int m, mism;
    logic modif;
    if (hung) return;
    if (exp_err) begin
      chk("R9 refused err", int'(got_err), 1);
      chk("R9 no select", ntx, 0);
      return;
    end
    chk("R9 accepted no err", int'(got_err), 0);
    chk("R2 bus timing", viol, 0);
    modif = (op >= 2 && op <= 6);
    m = modif ? 1 : 0;
    if (modif) begin
      chk("R5 R6 transaction count", ntx, 3);
      chk("R5 R6 write-enable alone", int'(lgn[0] == 1 && lg[0][0] == 8'h06), 1);
      chk("R7 poll opcode", int'(lg[2][0]), 8'h05);
      chk("R7 poll length", lgn[2], busy + 2);
      chk("R10 select gap", int'(min_gap >= GAPMIN), 1);
    end else begin
      chk("R3 R4 R8 single transaction", ntx, 1);
    end
    chk("R3 R4 R5 R6 R8 opcode", int'(lg[m][0]), int'(cmd_of(op)));
    if (op <= 5) chk("R3 R4 R5 R6 address", int'(log_addr(m)), int'(addr));
    mism = 0;
    case (op)
      0, 1: begin
        chk(op == 0 ? "R3 length" : "R4 length", lgn[0], (op == 0 ? 4 : 5) + len);
        chk("R3 R4 returned count", rd_n, len);
        for (int i = 0; i < len; i++)
          if (rd_buf[i] != mem_at(addr + 24'(i))) mism++;
        chk(op == 0 ? "R3 data order" : "R4 data order", mism, 0);
      end
      2: begin
        chk("R5 length", lgn[1], 4 + len);
        for (int i = 0; i < len; i++)
          if (lg[1][4 + i] != wr_buf[i]) mism++;
        chk("R5 data bytes", mism, 0);
      end
      3, 4, 5: chk("R6 length", lgn[1], 4);
      6: chk("R6 chip erase length", lgn[1], 1);
      default: begin
        chk("R8 length", lgn[0], 2);
        chk("R8 returned", int'(rd_n == 1 && rd_buf[0] == stat_val), 1);
      end
    endcase
  endtask

  task automatic fill_wr(input int n);
    for (int i = 0; i < n; i++) wr_buf[i] = 8'($urandom);
    wr_cnt = n;
  endtask

  initial begin
    logic [23:0] a;
    int op, len, bz;
    void'($urandom(32'd4242));
    for (int i = 0; i < MAXB; i++) wr_buf[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 select high", int'(flash_cs_n), 1);
    chk("R1 clock low", int'(flash_sck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 done low", int'(done), 0);

    wr_cnt = 0;
    run_op(0, 24'h123456, 5, 0, 8'h02);   check_op(0, 24'h123456, 5, 0, 1'b0);
    run_op(1, 24'h00FFFE, 4, 0, 8'h02);   check_op(1, 24'h00FFFE, 4, 0, 1'b0);
    fill_wr(16);
    run_op(2, 24'h0010F0, 16, 3, 8'h02);  check_op(2, 24'h0010F0, 16, 3, 1'b0);
    fill_wr(256);
    run_op(2, 24'h000100, 256, 0, 8'h02); check_op(2, 24'h000100, 256, 0, 1'b0);
    fill_wr(16);
    run_op(2, 24'h0000F1, 16, 0, 8'h02);  check_op(2, 24'h0000F1, 16, 0, 1'b1);
    run_op(2, 24'h000000, 0, 0, 8'h02);   check_op(2, 24'h000000, 0, 0, 1'b1);
    wr_cnt = 0;
    run_op(0, 24'h000010, 0, 0, 8'h02);   check_op(0, 24'h000010, 0, 0, 1'b1);
    run_op(3, 24'h123000, 0, 2, 8'h02);   check_op(3, 24'h123000, 0, 2, 1'b0);
    run_op(4, 24'h348000, 0, 1, 8'h02);   check_op(4, 24'h348000, 0, 1, 1'b0);
    run_op(5, 24'hAB0000, 0, 0, 8'h02);   check_op(5, 24'hAB0000, 0, 0, 1'b0);
    run_op(6, 24'h000000, 0, 4, 8'h02);   check_op(6, 24'h000000, 0, 4, 1'b0);
    run_op(7, 24'h000000, 0, 0, 8'hA4);   check_op(7, 24'h000000, 0, 0, 1'b0);

    for (int k = 0; k < 8; k++) begin
      op = $urandom % 3;
      a  = 24'($urandom);
      bz = $urandom % 4;
      if (op == 2) begin
        len = 1 + ($urandom % 32);
        if (int'(a[7:0]) + len > 256) len = 256 - int'(a[7:0]);
        fill_wr(len);
      end else begin
        len = 1 + ($urandom % 24);
        wr_cnt = 0;
      end
      run_op(op, a, len, bz, 8'h02);
      check_op(op, a, len, bz, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule